// File: doc/BRIEF.md
# Half-precision trigonometric series multiply-add

This block performs one term of a sine or cosine series evaluation on a single half-precision element. It takes a running partial value A, a reduced argument term B and a 3-bit term selector. It forms A multiplied by the magnitude of B and adds a constant series coefficient, with a single rounding at the end. The coefficient comes from a small built-in table. The sign bit of B selects the sine column (sign 0) or the cosine column (sign 1), and the selector picks the row. The sign of B never reaches the product. The coefficients suit reduced arguments x with -π/4 < x ≤ π/4.

The block is meant to be called repeatedly by a sequencer that walks the selector from the highest term down to zero. Each call feeds the last result back in as A. The result is meant to overwrite A's storage slot, and there is no mask input. A caller presents one element with `inValid` and gets the result, registered, on the next cycle with `outValid`. An element-size code travels with each request. Only the half-precision datapath is built, and the block reports the reserved size code on a registered flag.

Top module: `trig_series_fma`

## Requirements
- R1: When `inValid` is high at a rising edge, `outValid` is high after that edge and `result` holds the answer for that request. When `inValid` is low at an edge, `outValid` is low after it.
- R2: While `rstN` is low, `outValid`, `sizeIllegal` and `result` are all zero.
- R3: The product is A times |B|. Flipping bit 15 of B changes only which coefficient column is used, never the sign of the product.
- R4: With B bit 15 = 0, the coefficient for selector 0, 1 and 2 is 0x3C00, 0xB155 and 0x2030. For selectors 3 to 7 it is 0x0000.
- R5: With B bit 15 = 1, the coefficient for selector 0, 1 and 2 is 0x3C00, 0xB800 and 0x293A. For selectors 3 to 7 it is 0x0000.
- R6: The exact value A·|B| + coefficient is rounded once, to nearest with ties to even, into IEEE binary16.
- R7: Subnormal operands are used at full value, and results below 2^-14 come out as subnormals (LSB 2^-24) rather than being flushed.
- R8: A finite result whose rounded magnitude reaches 2^16 becomes infinity (0x7C00 or 0xFC00 by sign). A non-NaN input never yields a NaN encoding except in the invalid case of R9.
- R9: If A or B is a NaN (exponent field 31, nonzero fraction), or the product is infinity times zero, the result is 0x7E00.
- R10: If A or B is infinite and the other is nonzero and not NaN, the result is infinity with the sign of A (0x7C00 for A positive, 0xFC00 for A negative).
- R11: An exact zero sum is +0 (0x0000), unless both the product and the coefficient are negative zero. A nonzero result that rounds to zero keeps the sign of the exact sum.
- R12: The element-size code 2'b00 is reserved. A request carrying it raises `sizeIllegal` in the result cycle. Codes 2'b01 (half), 2'b10 (single) and 2'b11 (double) leave it low.
- R13: While `inValid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe for the current operands |
| opA | input | 16 | Binary16 partial value A (accumulator term) |
| opB | input | 16 | Binary16 operand B; its sign also picks the coefficient column |
| coefIdx | input | 3 | Series term selector, 0 to 7 |
| elemSize | input | 2 | Element-size code carried with the request |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| result | output | 16 | Registered binary16 result |
| sizeIllegal | output | 1 | Reserved size code seen on the request now being reported |

## Verification
Every table entry is reached with a zero product, so the raw coefficient appears at the output and each row and column is confirmed on its own. Paired requests that differ only in B's sign show that the sign steers the column and not the product. Hand-picked operands place results exactly on rounding ties, across the normal/subnormal boundary, at overflow, at exact cancellation and in each special-value case. These separate a correct single rounding from truncation, flushing or a lost sign. A large run of random operands, some shaped toward tiny and huge exponents, is compared with an independent wide-integer model. That run exposes alignment or sticky-bit errors that the directed cases would not reach.

// File: rtl/trigmad_pkg.sv
package trigmad_pkg;

  localparam int HALF_W   = 16;
  localparam int EXP_W    = 5;
  localparam int MAN_W    = 10;
  localparam int SIG_W    = MAN_W + 1;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam int PROD_W   = 2 * SIG_W;
  // Fixed-point grid: LSB weight is the square of the smallest subnormal.
  localparam int FIX_LSB_EXP = 2 * (1 - BIAS - MAN_W);
  localparam int PROD_OFF = -2 * (BIAS + MAN_W) - FIX_LSB_EXP;   // negative
  localparam int COEF_OFF = -(BIAS + MAN_W) - FIX_LSB_EXP;
  localparam int SHIFT_W  = 7;
  localparam int FIX_W    = PROD_W + 2 * (EXP_MAX - 1) + PROD_OFF + 2;
  localparam int SUB_LSB  = (1 - BIAS - MAN_W) - FIX_LSB_EXP;
  localparam int NORM_LEAD = SUB_LSB + MAN_W;
  localparam logic [HALF_W-1:0] QNAN = 16'h7E00;
  localparam logic [HALF_W-2:0] INF_MAG = 15'h7C00;

  typedef struct packed {
    logic capture;
    logic sizeBad;
  } ctrlStrobe_t;

  typedef struct packed {
    logic             sgn;
    logic             isNan;
    logic             isInf;
    logic             isZero;
    logic [SIG_W-1:0] sig;
    logic [EXP_W-1:0] expEff;
  } halfFields_t;

  function automatic halfFields_t unpackHalf(input logic [HALF_W-1:0] v);
    halfFields_t f;
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;
    e = v[HALF_W-2:MAN_W];
    m = v[MAN_W-1:0];
    f.sgn    = v[HALF_W-1];
    f.isNan  = (e == EXP_W'(EXP_MAX)) && (m != '0);
    f.isInf  = (e == EXP_W'(EXP_MAX)) && (m == '0);
    f.isZero = (e == '0) && (m == '0);
    f.sig    = {(e != '0), m};
    f.expEff = (e == '0) ? EXP_W'(1) : e;
    return f;
  endfunction

endpackage

// File: rtl/trigmad_coef_rom.sv
module trigmad_coef_rom
  import trigmad_pkg::*;
(
  input  logic              colCos,
  input  logic [2:0]        row,
  output logic [HALF_W-1:0] coef
);

  always_comb begin
    coef = '0;
    unique case ({colCos, row})
      4'b0_000: coef = 16'h3C00;
      4'b0_001: coef = 16'hB155;
      4'b0_010: coef = 16'h2030;
      4'b1_000: coef = 16'h3C00;
      4'b1_001: coef = 16'hB800;
      4'b1_010: coef = 16'h293A;
      default:  coef = 16'h0000;
    endcase
  end

endmodule

// File: rtl/trigmad_round.sv
module trigmad_round
  import trigmad_pkg::*;
(
  input  logic [FIX_W-1:0]  sumMag,
  input  logic              sumNeg,
  output logic [HALF_W-1:0] resBits
);

  logic [SHIFT_W-1:0] lead;
  logic [SHIFT_W-1:0] lsbPos;
  logic [SIG_W:0]     kept;
  logic [SIG_W:0]     rounded;
  logic               guardBit;
  logic               stickyBit;
  logic [19:0]        expBase;
  logic [19:0]        encSum;
  logic [FIX_W-1:0]   shifted;

  always_comb begin
    lead = '0;
    for (int i = 0; i < FIX_W; i++) begin
      if (sumMag[i]) lead = SHIFT_W'(i);
    end
    lsbPos    = (lead >= SHIFT_W'(NORM_LEAD)) ? (lead - SHIFT_W'(MAN_W)) : SHIFT_W'(SUB_LSB);
    shifted   = sumMag >> lsbPos;
    kept      = shifted[SIG_W:0];
    guardBit  = sumMag[lsbPos - SHIFT_W'(1)];
    stickyBit = |(sumMag & ~({FIX_W{1'b1}} << (lsbPos - SHIFT_W'(1))));
    rounded   = kept + {{SIG_W{1'b0}}, guardBit & (stickyBit | kept[0])};
    expBase   = (lead >= SHIFT_W'(NORM_LEAD)) ? 20'(lead - SHIFT_W'(NORM_LEAD)) : 20'd0;
    encSum    = (expBase << MAN_W) + 20'(rounded);
    if (encSum >= {5'd0, INF_MAG}) resBits = {sumNeg, INF_MAG};
    else                           resBits = {sumNeg, encSum[HALF_W-2:0]};
  end

endmodule

// File: rtl/trigmad_ctrl.sv
module trigmad_ctrl
  import trigmad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  elemSize,
  output ctrlStrobe_t strobe,
  output logic        outValid,
  output logic        sizeIllegal
);

  always_comb begin
    strobe.capture = inValid;
    strobe.sizeBad = (elemSize == 2'b00);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      sizeIllegal <= 1'b0;
    end else begin
      outValid    <= strobe.capture;
      sizeIllegal <= strobe.capture & strobe.sizeBad;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);                                    // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);                                  // R1
  AST_SIZE_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && elemSize != 2'b00) |=> !sizeIllegal);         // R12

endmodule

// File: rtl/trigmad_dp.sv
module trigmad_dp
  import trigmad_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [HALF_W-1:0] opA,
  input  logic [HALF_W-1:0] opB,
  input  logic [2:0]        coefIdx,
  output logic [HALF_W-1:0] result
);

  halfFields_t        fa, fb, fc;
  logic [HALF_W-1:0]  coef;
  logic [PROD_W-1:0]  prodSig;
  logic [SHIFT_W-1:0] prodShift, coefShift;
  logic [FIX_W-1:0]   prodFix, coefFix, sumMag;
  logic               prodNeg, coefNeg, sumNeg;
  logic               invalidOp, infOut, nanIn;
  logic [HALF_W-1:0]  roundedBits, nextResult;

  trigmad_coef_rom u_rom (
    .colCos (opB[HALF_W-1]),
    .row    (coefIdx),
    .coef   (coef)
  );

  always_comb begin
    fa = unpackHalf(opA);
    fb = unpackHalf(opB);
    fc = unpackHalf(coef);
    prodSig   = PROD_W'(fa.sig) * PROD_W'(fb.sig);
    prodShift = SHIFT_W'(fa.expEff) + SHIFT_W'(fb.expEff) - SHIFT_W'(-PROD_OFF);
    coefShift = SHIFT_W'(fc.expEff) + SHIFT_W'(COEF_OFF);
    prodFix   = FIX_W'(prodSig) << prodShift;
    coefFix   = FIX_W'(fc.sig) << coefShift;
    prodNeg   = fa.sgn;          // magnitude of B: its sign is dropped
    coefNeg   = fc.sgn;
    if (prodNeg == coefNeg) begin
      sumMag = prodFix + coefFix;
      sumNeg = prodNeg;
    end else if (prodFix >= coefFix) begin
      sumMag = prodFix - coefFix;
      sumNeg = prodNeg;
    end else begin
      sumMag = coefFix - prodFix;
      sumNeg = coefNeg;
    end
  end

  trigmad_round u_round (
    .sumMag  (sumMag),
    .sumNeg  (sumNeg),
    .resBits (roundedBits)
  );

  always_comb begin
    nanIn     = fa.isNan | fb.isNan;
    invalidOp = nanIn | (fa.isInf & fb.isZero) | (fa.isZero & fb.isInf);
    infOut    = fa.isInf | fb.isInf;
    if (invalidOp)            nextResult = QNAN;
    else if (infOut)          nextResult = {prodNeg, INF_MAG};
    else if (sumMag == '0)    nextResult = {prodNeg & coefNeg, {(HALF_W-1){1'b0}}};
    else                      nextResult = roundedBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               result <= '0;
    else if (strobe.capture) result <= nextResult;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(result));                                   // R13
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && nanIn) |=> (result == QNAN));                        // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !invalidOp) |=>
      (result[HALF_W-2:MAN_W] != EXP_W'(EXP_MAX) || result[MAN_W-1:0] == '0)); // R8
  AST_INF_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && infOut && !invalidOp) |=> (result[HALF_W-1] == $past(opA[HALF_W-1]))); // R10

endmodule

// File: rtl/trig_series_fma.sv
module trig_series_fma
  import trigmad_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [2:0]  coefIdx,
  input  logic [1:0]  elemSize,
  output logic        outValid,
  output logic [15:0] result,
  output logic        sizeIllegal
);

  ctrlStrobe_t strobe;

  trigmad_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .elemSize    (elemSize),
    .strobe      (strobe),
    .outValid    (outValid),
    .sizeIllegal (sizeIllegal)
  );

  trigmad_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .opA     (opA),
    .opB     (opB),
    .coefIdx (coefIdx),
    .result  (result)
  );

endmodule

// File: tb/trig_series_fma_tb.sv
module trig_series_fma_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [2:0]  coefIdx = '0;
  logic [1:0]  elemSize = 2'b01;
  logic        outValid, sizeIllegal;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] res;
    logic        bad;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  trig_series_fma u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .coefIdx(coefIdx), .elemSize(elemSize), .outValid(outValid),
    .result(result), .sizeIllegal(sizeIllegal)
  );

  function automatic logic [15:0] tableVal(input logic s, input logic [2:0] k);
    if (k == 3'd0) return 16'h3C00;
    if (k == 3'd1) return s ? 16'hB800 : 16'hB155;
    if (k == 3'd2) return s ? 16'h293A : 16'h2030;
    return 16'h0000;
  endfunction

  // Independent model: exact integer sum scaled by 2^48, then bit-serial rounding.
  function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b, input logic [2:0] k);
    logic [15:0] c;
    logic signed [127:0] pv, cv, sum;
    logic [127:0] q;
    int ex;
    bit g, st, neg;
    logic [10:0] sa, sb2, sc;
    int ea, eb, ec;
    c = tableVal(b[15], k);
    if ((a[14:10] == 31 && a[9:0] != 0) || (b[14:10] == 31 && b[9:0] != 0)) return 16'h7E00;
    if ((a[14:10] == 31 && b[14:0] == 0) || (b[14:10] == 31 && a[14:0] == 0)) return 16'h7E00;
    if (a[14:10] == 31 || b[14:10] == 31) return {a[15], 15'h7C00};
    sa = {a[14:10] != 0, a[9:0]}; ea = (a[14:10] == 0) ? 1 : int'(a[14:10]);
    sb2 = {b[14:10] != 0, b[9:0]}; eb = (b[14:10] == 0) ? 1 : int'(b[14:10]);
    sc = {c[14:10] != 0, c[9:0]}; ec = (c[14:10] == 0) ? 1 : int'(c[14:10]);
    pv = (128'(sa) * 128'(sb2)) <<< (ea + eb - 2);
    cv = 128'(sc) <<< (ec + 23);
    if (a[15]) pv = -pv;
    if (c[15]) cv = -cv;
    sum = pv + cv;
    if (sum == 0) return {(a[15] && c[15] && a[14:0] == 0 && b[14:0] == 0 && c[14:0] == 0), 15'h0};
    neg = sum < 0;
    q = neg ? 128'(-sum) : 128'(sum);
    ex = -48; g = 0; st = 0;
    while (q >= 2048 || ex < -24) begin
      st = st | g; g = q[0]; q = q >> 1; ex++;
    end
    if (g && (st || q[0])) q++;
    if (q == 2048) begin q = 1024; ex++; end
    if (q < 1024) return {neg, 5'd0, q[9:0]};
    if (ex + 25 >= 31) return {neg, 15'h7C00};
    return {neg, 5'(ex + 25), q[9:0]};
  endfunction

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic [2:0] k,
                      input logic [1:0] sz, input logic [15:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    opA = a; opB = b; coefIdx = k; elemSize = sz; inValid = 1'b1;
    it.res = exp; it.bad = (sz == 2'b00); it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      opA = 16'hFFFF; opB = 16'h1234; coefIdx = 3'd5; elemSize = 2'b00;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor
  logic [15:0] lastRes = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (outValid) begin
          if (sb.size() == 0) check(0, "R1 unexpected outValid", result, lastRes);
          else begin
            item_t it;
            it = sb.pop_front();
            check(result == it.res, it.tag, result, it.res);
            check(sizeIllegal == it.bad, "R12 sizeIllegal", {15'd0, sizeIllegal}, {15'd0, it.bad});
          end
          lastRes = result;
        end else begin
          check(sb.size() == 0, "R1 missing outValid", 16'(sb.size()), 16'd0);
          check(result == lastRes, "R13 hold", result, lastRes);
        end
      end
    end
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(outValid == 0 && result == 0 && sizeIllegal == 0, "R2 reset", result, 16'h0);
    rstN = 1'b1;
    idle(2);
    // R4 / R5: zero product exposes every coefficient
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++)
        send(16'h0000, s ? 16'h8000 : 16'h0000, 3'(k), 2'b01,
             tableVal(s[0], 3'(k)), s ? "R5 table" : "R4 table");
    idle(2);
    // R3: sign of B only steers column
    send(16'h3C00, 16'h3C00, 3'd0, 2'b01, 16'h4000, "R3 B positive");
    send(16'h3C00, 16'hBC00, 3'd1, 2'b10, 16'h3800, "R3 B negative");
    send(16'h3C00, 16'hC000, 3'd3, 2'b11, 16'h4000, "R3 product sign");
    // R6 ties to even and sticky
    send(16'h1000, 16'h3C00, 3'd0, 2'b01, 16'h3C00, "R6 tie even");
    send(16'h1000, 16'h3C01, 3'd0, 2'b01, 16'h3C01, "R6 sticky up");
    // R7 subnormals
    send(16'h0001, 16'h3C00, 3'd3, 2'b01, 16'h0001, "R7 subnormal pass");
    send(16'h0003, 16'h3800, 3'd4, 2'b01, 16'h0002, "R7 subnormal tie");
    send(16'h0001, 16'h3800, 3'd5, 2'b01, 16'h0000, "R7 R11 tie to zero");
    send(16'h0200, 16'h4000, 3'd6, 2'b01, 16'h0400, "R7 to normal");
    // R8 overflow
    send(16'h7BFF, 16'h7BFF, 3'd0, 2'b01, 16'h7C00, "R8 overflow pos");
    send(16'hFBFF, 16'h7BFF, 3'd0, 2'b01, 16'hFC00, "R8 overflow neg");
    // R9 / R10
    send(16'h7C01, 16'h3C00, 3'd0, 2'b01, 16'h7E00, "R9 NaN A");
    send(16'h3C00, 16'hFE55, 3'd1, 2'b01, 16'h7E00, "R9 NaN B");
    send(16'h7C00, 16'h0000, 3'd0, 2'b01, 16'h7E00, "R9 inf times zero");
    send(16'h7C00, 16'hC000, 3'd1, 2'b01, 16'h7C00, "R10 inf sign A");
    send(16'hFC00, 16'h4000, 3'd1, 2'b01, 16'hFC00, "R10 neg inf");
    // R11 signed zero
    send(16'hBC00, 16'h3C00, 3'd0, 2'b01, 16'h0000, "R11 cancel");
    send(16'h8000, 16'h3C00, 3'd3, 2'b01, 16'h0000, "R11 neg zero plus zero");
    // R12 reserved size
    send(16'h3C00, 16'h3C00, 3'd0, 2'b00, 16'h4000, "R12 reserved code");
    idle(3);
    // Random against model (R6 broad)
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a, b;
      logic [2:0] k;
      a = 16'($urandom); b = 16'($urandom); k = 3'($urandom);
      if (n % 3 == 1) a[14:13] = 2'b00;
      if (n % 5 == 2) b[14:12] = 3'b000;
      if (n % 7 == 3) begin a[14:12] = 3'b011; b[14:12] = 3'b011; end
      send(a, b, k, 2'(1 + n % 3), model(a, b, k), "R6 random vs model");
      if (n % 97 == 0) idle(1);
    end
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule